// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block adds two unsigned N-bit words and a single carry-in bit, giving an N-bit sum and a carry-out. It is purely combinational and holds no state. It is meant for a datapath that needs a wide add inside one cycle with a short carry path. N defaults to 128, and the block is also built at 16, 32 and 64 bits.

The operand word is cut into groups. Counting from the least significant end, the groups are 2, 3, 4 and so on bits wide. The last group also takes any bits left over, so the widths add up to exactly N. Every bit works out both of its sum candidates with one XOR and an inverter, and both of its carry candidates with one AND and one OR.

From these shared terms each group builds two carry chains: one assumes a zero carry into the group, the other assumes a one. The real carry into the group then selects, through multiplexers, the carry seen by each bit and the carry handed to the next group. That selected carry in turn picks each bit's sum candidate. Because each group is only a little wider than the one before, its internal chain settles at about the time its select carry arrives.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every input combination, {cout_o, sum_o} equals the (N+1)-bit value of a_i + b_i + cin_i.
- R2: Bit 0 of sum_o equals a_i[0] XOR b_i[0] XOR cin_i, because the first group is fed directly by the external carry-in.
- R3: When a_i is all ones, b_i is zero and cin_i is 1, sum_o is all zeros and cout_o is 1.
- R4: When both operands are zero, sum_o equals cin_i zero-extended to N bits and cout_o is 0.
- R5: cout_o is the carry leaving bit N-1. It equals a_i[N-1] AND b_i[N-1], OR'd with (a_i[N-1] XOR b_i[N-1]) AND NOT sum_o[N-1].
- R6: Group widths start at 2 bits and grow by one bit per group, and the last group absorbs any remainder so that the widths sum to N. The adder computes correct results when N is 16, 32, 64 and 128.
- R7: With a_i holding ones in its low k bits and zeros above, b_i zero and cin_i 1, sum_o equals 2^k, for every k from 1 to N-1. For k = N, the result wraps to zero with cout_o 1. This makes the carry cross every group boundary.
- R8: With alternating bit patterns (a_i = 0101…, b_i = 1010…), the sum is all ones and cout_o is 0 when cin_i is 0. When cin_i is 1, the sum is zero and cout_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand, unsigned |
| b_i | input | N | Second operand, unsigned |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | N | Low N bits of the total |
| cout_o | output | 1 | Carry out of bit N-1 |

## Verification
The two functions that meet in the same evaluation are a group's own precomputed carry hypothesis and the select carry arriving from below. A wrong pairing would only show when a group generates or kills internally while a real carry also comes in from below. The bench provokes this with runs of low-order ones plus a carry-in, so that the incoming carry must cross each group boundary in turn. It also uses alternating patterns in which every bit propagates, and random words with both carry-in values. Every result at all four widths is judged against an independent behavioural addition, masked to that width.

// File: rtl/cs_pkg.sv
// Package: group layout arithmetic for the square-root carry-select adder.
// Assumes widths of at least 2 bits; group g (counted from bit 0) is g+2 bits
// wide, except the last, which also takes the leftover bits.
package cs_pkg;

    // Number of groups for an n-bit adder.
    function automatic int cs_num_groups(input int n);
        int used;
        int w;
        int g;
        used = 0;
        w    = 2;
        g    = 0;
        while (used + w <= n) begin
            used = used + w;
            w    = w + 1;
            g    = g + 1;
        end
        if (g == 0) begin
            g = 1;
        end
        return g;
    endfunction

    // Index of the lowest bit of group g.
    function automatic int cs_group_lsb(input int g);
        return (g * (g + 3)) / 2;
    endfunction

    // Width of group g in an n-bit adder.
    function automatic int cs_group_width(input int n, input int g);
        if (g == cs_num_groups(n) - 1) begin
            return n - cs_group_lsb(g);
        end
        return g + 2;
    endfunction

endpackage

// File: rtl/cs_bit_cell.sv
// Module: cs_bit_cell
// Produces the shared per-bit terms for both carry hypotheses: the sum
// candidates come from one XOR and one inverter, and the carry candidates
// from one AND and one OR. Purely combinational.
module cs_bit_cell (
    input  logic a_i,
    input  logic b_i,
    output logic sum0_o,
    output logic sum1_o,
    output logic cry0_o,
    output logic cry1_o
);

    logic half_sum;

    // Shared terms: a single XOR feeds both sum candidates.
    always_comb begin
        half_sum = a_i ^ b_i;
        sum0_o   = half_sum;
        sum1_o   = ~half_sum;
        cry0_o   = a_i & b_i;
        cry1_o   = a_i | b_i;
    end

endmodule

// File: rtl/cs_mux2.sv
// Module: cs_mux2
// Two-way selector driven by a resolved carry. Width is a parameter.
module cs_mux2 #(
    parameter int W = 1
) (
    input  logic         sel_i,
    input  logic [W-1:0] in0_i,
    input  logic [W-1:0] in1_i,
    output logic [W-1:0] out_o
);

    // Pick the candidate matching the selecting carry.
    always_comb begin
        out_o = sel_i ? in1_i : in0_i;
    end

endmodule

// File: rtl/cs_group.sv
// Module: cs_group
// One carry-select group of W bits. Two carry chains are built from the
// shared per-bit terms: one assuming carry 0 into the group, one assuming 1.
// The real group carry then selects each bit's carry, each bit's sum
// candidate, and the carry leaving the group. Assumes W >= 1.
module cs_group #(
    parameter int W = 2
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    logic [W-1:0] s0;
    logic [W-1:0] s1;
    logic [W-1:0] k0;
    logic [W-1:0] k1;
    logic [W:0]   chain0;
    logic [W:0]   chain1;
    logic [W:0]   real_cry;

    assign chain0[0] = 1'b0;
    assign chain1[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        cs_bit_cell cell_i (
            .a_i    (a_i[i]),
            .b_i    (b_i[i]),
            .sum0_o (s0[i]),
            .sum1_o (s1[i]),
            .cry0_o (k0[i]),
            .cry1_o (k1[i])
        );

        // Hypothesis chains: each bit forwards generate or propagate.
        cs_mux2 #(.W(2)) hyp_i (
            .sel_i (1'b0),
            .in0_i ({chain1[i] ? k1[i] : k0[i], chain0[i] ? k1[i] : k0[i]}),
            .in1_i (2'b00),
            .out_o ({chain1[i+1], chain0[i+1]})
        );

        // Real carry into bit i, picked by the group carry.
        cs_mux2 #(.W(1)) csel_i (
            .sel_i (cin_i),
            .in0_i (chain0[i]),
            .in1_i (chain1[i]),
            .out_o (real_cry[i])
        );

        // Final sum bit, picked by the real carry into the bit.
        cs_mux2 #(.W(1)) ssel_i (
            .sel_i (real_cry[i]),
            .in0_i (s0[i]),
            .in1_i (s1[i]),
            .out_o (sum_o[i])
        );
    end

    // Group carry-out chosen from the two precomputed candidates.
    cs_mux2 #(.W(1)) osel_i (
        .sel_i (cin_i),
        .in0_i (chain0[W]),
        .in1_i (chain1[W]),
        .out_o (real_cry[W])
    );

    assign cout_o = real_cry[W];

endmodule

// File: rtl/sqrt_csel_adder.sv
// Module: sqrt_csel_adder
// Top of the square-root carry-select adder. Cuts the N-bit operands into
// groups of growing width (2, 3, 4, ...; the last takes the remainder) and
// chains the group carries. Purely combinational; no clock or reset.
// Assumes N >= 2.
module sqrt_csel_adder #(
    parameter int N = 128
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         cin_i,
    output logic [N-1:0] sum_o,
    output logic         cout_o
);

    import cs_pkg::*;

    localparam int NG = cs_num_groups(N);

    logic [NG:0] grp_cry;

    assign grp_cry[0] = cin_i;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        localparam int LSB = cs_group_lsb(g);
        localparam int GW  = cs_group_width(N, g);

        cs_group #(.W(GW)) grp_i (
            .a_i    (a_i[LSB +: GW]),
            .b_i    (b_i[LSB +: GW]),
            .cin_i  (grp_cry[g]),
            .sum_o  (sum_o[LSB +: GW]),
            .cout_o (grp_cry[g+1])
        );
    end

    assign cout_o = grp_cry[NG];

endmodule

// Checker: port-level relations of the adder, evaluated whenever they settle.
module sqrt_csel_adder_chk #(
    parameter int N = 128
) (
    input logic [N-1:0] a_i,
    input logic [N-1:0] b_i,
    input logic         cin_i,
    input logic [N-1:0] sum_o,
    input logic         cout_o
);

    logic [N:0] ref_total;

    // Independent behavioural total.
    always_comb begin
        ref_total = {1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, cin_i};
    end

    // Relations between the operands and the results.
    always_comb begin
        assert_full_total_R1: assert ({cout_o, sum_o} == ref_total)
            else $error("R1 total mismatch");
        assert_low_bit_R2: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ cin_i))
            else $error("R2 bit 0 mismatch");
        if ((&a_i) && (b_i == '0) && cin_i) begin
            assert_wrap_R3: assert ((sum_o == '0) && cout_o)
                else $error("R3 wrap mismatch");
        end
        if ((a_i == '0) && (b_i == '0)) begin
            assert_zero_ops_R4: assert ((sum_o == {{(N-1){1'b0}}, cin_i}) && !cout_o)
                else $error("R4 zero operand mismatch");
        end
        assert_top_carry_R5: assert (cout_o ==
            ((a_i[N-1] & b_i[N-1]) | ((a_i[N-1] ^ b_i[N-1]) & ~sum_o[N-1])))
            else $error("R5 carry-out mismatch");
    end

endmodule

bind sqrt_csel_adder sqrt_csel_adder_chk #(.N(N)) chk_i (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .sum_o  (sum_o),
    .cout_o (cout_o)
);

// File: tb/sqrt_csel_adder_tb.sv
// Bench: directed scenarios, one task each, applied at once to adders
// built at 16, 32, 64 and 128 bits and compared to a masked behavioural sum.
module sqrt_csel_adder_tb_top;

    logic         clk   = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] a_r   = '0;
    logic [127:0] b_r   = '0;
    logic         cin_r = 1'b0;

    logic [15:0]  s16;
    logic [31:0]  s32;
    logic [63:0]  s64;
    logic [127:0] s128;
    logic         c16;
    logic         c32;
    logic         c64;
    logic         c128;

    int checks = 0;
    int bad    = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sqrt_csel_adder #(.N(128)) dut_i (
        .a_i (a_r), .b_i (b_r), .cin_i (cin_r), .sum_o (s128), .cout_o (c128)
    );
    sqrt_csel_adder #(.N(64)) dut64_i (
        .a_i (a_r[63:0]), .b_i (b_r[63:0]), .cin_i (cin_r), .sum_o (s64), .cout_o (c64)
    );
    sqrt_csel_adder #(.N(32)) dut32_i (
        .a_i (a_r[31:0]), .b_i (b_r[31:0]), .cin_i (cin_r), .sum_o (s32), .cout_o (c32)
    );
    sqrt_csel_adder #(.N(16)) dut16_i (
        .a_i (a_r[15:0]), .b_i (b_r[15:0]), .cin_i (cin_r), .sum_o (s16), .cout_o (c16)
    );

    // Compare one width against the masked behavioural sum.
    task automatic check_width(input string req, input int w, input logic [128:0] got);
        logic [128:0] m;
        logic [128:0] ea;
        logic [128:0] eb;
        logic [128:0] expv;
        m    = (129'd1 << w) - 129'd1;
        ea   = {1'b0, a_r} & m;
        eb   = {1'b0, b_r} & m;
        expv = ea + eb + {128'd0, cin_r};
        checks++;
        if (got !== expv) begin
            bad++;
            $display("FAIL %s N=%0d actual=%h expected=%h", req, w, got, expv);
        end
    endtask

    task automatic check_all(input string req);
        check_width(req, 16,  {112'd0, c16, s16});
        check_width(req, 32,  {96'd0, c32, s32});
        check_width(req, 64,  {64'd0, c64, s64});
        check_width(req, 128, {c128, s128});
    endtask

    // Drive away from the clock edge, let it settle, then check.
    task automatic apply(input logic [127:0] a, input logic [127:0] b,
                         input logic c, input string req);
        @(negedge clk);
        a_r   = a;
        b_r   = b;
        cin_r = c;
        #1;
        check_all(req);
    endtask

    // Reset phase: zero inputs give zero outputs (R4).
    task automatic t_reset();
        @(negedge clk);
        #1;
        check_all("R4 reset");
        rst_n = 1'b1;
    endtask

    task automatic t_zeros();
        apply('0, '0, 1'b0, "R4 zeros cin0");
        apply('0, '0, 1'b1, "R4 zeros cin1");
    endtask

    // All ones plus one at every width (R3), masked per width by the model.
    task automatic t_all_ones();
        apply({128{1'b1}}, '0, 1'b1, "R3 ones+cin");
        apply({128{1'b1}}, 128'd1, 1'b0, "R3 ones+b1");
        apply({128{1'b1}}, {128{1'b1}}, 1'b1, "R1 ones+ones+cin");
    endtask

    task automatic t_alternating();
        apply({64{2'b01}}, {64{2'b10}}, 1'b0, "R8 alt cin0");
        apply({64{2'b01}}, {64{2'b10}}, 1'b1, "R8 alt cin1");
        apply({64{2'b10}}, {64{2'b10}}, 1'b1, "R8 alt same");
    endtask

    // Carry crossing every group boundary (R7, R6).
    task automatic t_boundaries();
        for (int k = 1; k <= 128; k++) begin
            apply((k == 128) ? {128{1'b1}} : ((128'd1 << k) - 128'd1), '0, 1'b1, "R7 run");
            apply('0, (k == 128) ? {128{1'b1}} : ((128'd1 << k) - 128'd1), 1'b1, "R6 run b");
        end
    endtask

    // Random operands with both carry-in values (R1, R2, R5).
    task automatic t_random();
        for (int n = 0; n < 300; n++) begin
            apply({$urandom, $urandom, $urandom, $urandom},
                  {$urandom, $urandom, $urandom, $urandom},
                  n[0], "R1 R2 R5 random");
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_zeros();
        t_all_ones();
        t_alternating();
        t_boundaries();
        t_random();
        summary();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        summary();
    end

endmodule